// File: doc/BRIEF.md
# Dual-Clock Parallel-Load Shift Register

This block is an eight-stage shift register for a synchronous design. It runs entirely on a fast system clock. A second, slow "shift clock" domain is formed by two external clock lines that are ORed together. Every external input first passes through a two-flop synchroniser. The block then watches the combined shift clock for a low-to-high transition. Each such transition moves the register one place toward the last stage and takes a new bit from the serial input.

A low level on the load control copies the parallel inputs into all stages on every system cycle for as long as it is held. This load overrides any clock activity. Because the two clock lines are ORed, holding either one high blocks edges from the other, so either line can act as an active-low clock enable. The price is that raising such an enable while the other line is low is itself seen as a clock edge. The block drives the content of the final stage and its inverse.

Top module: `pls_shifter`

## Requirements
- R1: While `load_n` (after synchronisation) is 0, stage i takes `par_in[i]` on every system clock, whatever the shift-clock lines do. A change of `par_in` during the load is followed.
- R2: With load inactive, a 0-to-1 transition of (`shclk_a` OR `shclk_b`) shifts once: stage 0 takes `ser_in` and stage i takes stage i-1. Either line can produce the edge while the other is 0.
- R3: With load inactive and no rising edge of the combined clock, the stages keep their values. This includes a falling edge of the combined clock.
- R4: While either clock line is held at 1, pulses on the other line cause no shift.
- R5: Raising one line while the other is 0 causes exactly one shift.
- R6: `q_last` is stage 7 (the last stage) and `q_last_n` is its inverse at all times.
- R7: An input change made before system edge k reaches the stages at edge k+2. It is therefore visible on the outputs after the third system edge counted from the change.
- R8: No shift occurs on the first system cycle after the synchronised load returns to 1. This holds even if the combined clock is already 1, or rises together with the load release.
- R9: A synchronous active-high `rst` clears all stages and the edge-detector history to 0. After reset the outputs read 0 and 1.
- R10: After a parallel load of P followed by shifts, `q_last` presents P[7], P[6], ... P[0] in turn. It then presents the serial bits in the order they were shifted in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shclk_a | input | 1 | First shift-clock line (asynchronous) |
| shclk_b | input | 1 | Second shift-clock line (asynchronous) |
| ser_in | input | 1 | Serial data entering stage 0 |
| load_n | input | 1 | Active-low level-sensitive parallel load |
| par_in | input | WIDTH | Parallel data, bit i to stage i |
| q_last | output | 1 | Content of the final stage |
| q_last_n | output | 1 | Inverse of the final stage |

## Verification
The bench goes after four corner cases:
- Raising the inhibit line while the other line is low must give exactly one shift. A design that ignored this edge would leave the register unshifted, and one that double-detected it would skip a bit.
- The load is released with the clock already high, and also with the clock rising in the same cycle. A detector without release suppression would shift a spurious bit here.
- The parallel inputs are changed during a load. A clocked-only load would miss the second pattern.
- A full load-then-shift sequence confirms bit ordering. A reversed shift direction would present P0 first.

// File: rtl/pls_pkg.sv
package pls_pkg;

    localparam int DEFAULT_WIDTH  = 8;
    localparam int DEFAULT_STAGES = 2;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } op_e;

    typedef struct packed {
        logic ld_n;
        logic clk_a;
        logic clk_b;
        logic ser;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{ld_n: 1'b1, clk_a: 1'b0, clk_b: 1'b0, ser: 1'b0};

    // Load outranks shifting; shifting outranks holding.
    function automatic op_e pick_op(input logic ld_n, input logic shift);
        if (!ld_n)
            return OP_LOAD;
        else if (shift)
            return OP_SHIFT;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/pls_sync.sv
module pls_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] chain [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_flop
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= RST_VAL;
                else     chain[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= RST_VAL;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/pls_edge.sv
module pls_edge (
    input  logic clk,
    input  logic rst,
    input  logic clk_a,
    input  logic clk_b,
    input  logic ld_n,
    output logic shift_pulse
);

    logic comb;
    logic comb_prev;
    logic ld_n_prev;

    assign comb = clk_a | clk_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            comb_prev <= 1'b0;
            ld_n_prev <= 1'b0;
        end else begin
            comb_prev <= comb;
            ld_n_prev <= ld_n;
        end
    end

    // Edge counts only when load was already inactive on the previous cycle.
    assign shift_pulse = comb & ~comb_prev & ld_n & ld_n_prev;

endmodule

// File: rtl/pls_stages.sv
module pls_stages
    import pls_pkg::*;
#(
    parameter int W = DEFAULT_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  op_e          op,
    input  logic         ser,
    input  logic [W-1:0] par,
    output logic [W-1:0] stages
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stages <= '0;
        end else begin
            case (op)
                OP_LOAD:  stages <= par;
                OP_SHIFT: stages <= {stages[W-2:0], ser};
                default:  stages <= stages;
            endcase
        end
    end

endmodule

// File: rtl/pls_shifter.sv
module pls_shifter
    import pls_pkg::*;
#(
    parameter int WIDTH  = DEFAULT_WIDTH,
    parameter int STAGES = DEFAULT_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shclk_a,
    input  logic             shclk_b,
    input  logic             ser_in,
    input  logic             load_n,
    input  logic [WIDTH-1:0] par_in,
    output logic             q_last,
    output logic             q_last_n
);

    localparam int CW = $bits(ctrl_t);

    ctrl_t            ctrl_raw;
    ctrl_t            ctrl_s;
    logic [WIDTH-1:0] p_s;
    logic             shift_pulse;
    op_e              op;
    logic [WIDTH-1:0] stages;

    assign ctrl_raw = '{ld_n: load_n, clk_a: shclk_a, clk_b: shclk_b, ser: ser_in};

    pls_sync #(.W(CW), .STAGES(STAGES), .RST_VAL(CTRL_IDLE)) u_sync_ctrl (
        .clk  (clk),
        .rst  (rst),
        .din  (ctrl_raw),
        .dout (ctrl_s)
    );

    pls_sync #(.W(WIDTH), .STAGES(STAGES), .RST_VAL('0)) u_sync_par (
        .clk  (clk),
        .rst  (rst),
        .din  (par_in),
        .dout (p_s)
    );

    pls_edge u_edge (
        .clk         (clk),
        .rst         (rst),
        .clk_a       (ctrl_s.clk_a),
        .clk_b       (ctrl_s.clk_b),
        .ld_n        (ctrl_s.ld_n),
        .shift_pulse (shift_pulse)
    );

    assign op = pick_op(ctrl_s.ld_n, shift_pulse);

    pls_stages #(.W(WIDTH)) u_stages (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .ser    (ctrl_s.ser),
        .par    (p_s),
        .stages (stages)
    );

    assign q_last   = stages[WIDTH-1];
    assign q_last_n = ~stages[WIDTH-1];

endmodule

// File: rtl/pls_shifter_chk.sv
module pls_shifter_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             ld_n_s,
    input logic             ser_s,
    input logic [WIDTH-1:0] p_s,
    input logic             shift_pulse,
    input logic [WIDTH-1:0] stages
);

    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (stages == '0));

    a_r1_load_copies: assert property (@(posedge clk) disable iff (rst)
        !ld_n_s |=> (stages == $past(p_s)));

    a_r2_shift_moves: assert property (@(posedge clk) disable iff (rst)
        (ld_n_s && shift_pulse) |=>
            (stages == {$past(stages[WIDTH-2:0]), $past(ser_s)}));

    a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (ld_n_s && !shift_pulse) |=> $stable(stages));

    a_r8_release_quiet: assert property (@(posedge clk) disable iff (rst)
        $rose(ld_n_s) |-> !shift_pulse);

    a_r5_single_shift: assert property (@(posedge clk) disable iff (rst)
        shift_pulse |=> !shift_pulse);

endmodule

bind pls_shifter pls_shifter_chk #(.WIDTH(WIDTH)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .ld_n_s      (ctrl_s.ld_n),
    .ser_s       (ctrl_s.ser),
    .p_s         (p_s),
    .shift_pulse (shift_pulse),
    .stages      (stages)
);

// File: tb/pls_shifter_tb_top.sv
module pls_shifter_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         shclk_a = 1'b0;
    logic         shclk_b = 1'b0;
    logic         ser_in = 1'b0;
    logic         load_n = 1'b1;
    logic [W-1:0] par_in = '0;
    logic         q_last;
    logic         q_last_n;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    pls_shifter #(.WIDTH(W)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .shclk_a  (shclk_a),
        .shclk_b  (shclk_b),
        .ser_in   (ser_in),
        .load_n   (load_n),
        .par_in   (par_in),
        .q_last   (q_last),
        .q_last_n (q_last_n)
    );

    // Behavioural reference: remembers what the pins held at recent edges.
    typedef struct {
        bit           valid;
        bit           ldn;
        bit           cor;
        bit           ser;
        logic [W-1:0] par;
    } sample_t;

    sample_t      h1, h2, h3;
    logic [W-1:0] mref = '0;

    always @(posedge clk) begin
        sample_t cur;
        cur.valid = 1'b1;
        cur.ldn   = load_n;
        cur.cor   = shclk_a | shclk_b;
        cur.ser   = ser_in;
        cur.par   = par_in;
        if (rst) begin
            mref = '0;
            cur.valid = 1'b0;
        end else if (h2.valid && !h2.ldn) begin
            mref = h2.par;
        end else if (h2.valid && h2.cor && h3.valid && h3.ldn && !h3.cor) begin
            mref = {mref[W-2:0], h2.ser};
        end
        h3 = h2;
        h2 = h1;
        h1 = cur;
    end

    always @(negedge clk) begin
        if (!done) begin
            vectors++;
            if (q_last !== mref[W-1] || q_last_n !== ~mref[W-1]) begin
                fails++;
                $display("FAIL R7 model compare: got %b/%b expected %b/%b",
                         q_last, q_last_n, mref[W-1], ~mref[W-1]);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic exp);
        vectors++;
        if (q_last !== exp || q_last_n !== ~exp) begin
            fails++;
            $display("FAIL %s: got %b/%b expected %b/%b", tag, q_last, q_last_n, exp, ~exp);
        end
    endtask

    task automatic do_load(input logic [W-1:0] v);
        par_in = v;
        load_n = 1'b0;
        tick(4);
        load_n = 1'b1;
        tick(4);
    endtask

    task automatic pulse(input bit use_b);
        if (use_b) shclk_b = 1'b1; else shclk_a = 1'b1;
        tick(3);
        if (use_b) shclk_b = 1'b0; else shclk_a = 1'b0;
        tick(3);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            fails++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] pv;
        logic [W-1:0] sv;
        h1 = '{default: 0};
        h2 = '{default: 0};
        h3 = '{default: 0};

        tick(3);
        rst = 1'b0;
        chk("R9 reset state", 1'b0);

        // R1: load follows par_in and ignores clock toggles
        par_in = 8'hB4;
        load_n = 1'b0;
        tick(4);
        chk("R1 load msb", 1'b1);
        shclk_a = 1'b1; tick(2); shclk_a = 1'b0; tick(2);
        shclk_a = 1'b1; par_in = 8'h3C; tick(2); shclk_a = 1'b0; tick(3);
        chk("R1 load follows new data", 1'b0);
        par_in = 8'hB4;
        tick(4);
        load_n = 1'b1;
        tick(4);
        chk("R1 load held after release", 1'b1);

        // R10 / R2: full sequence, alternating clock lines
        pv = 8'hB4;
        sv = 8'hCA;
        for (int i = 0; i < 16; i++) begin
            chk(i < 8 ? "R10 parallel bit order" : "R10 serial bit order",
                i < 8 ? pv[7-i] : sv[i-8]);
            ser_in = sv[i % 8];
            pulse(i % 2 == 1);
        end

        // R5 / R4 / R3: inhibit behaviour
        do_load(8'h5A);
        chk("R1 load 5A", 1'b0);
        shclk_b = 1'b1;
        tick(4);
        chk("R5 inhibit rise gives one shift", 1'b1);
        pulse(1'b0); pulse(1'b0); pulse(1'b0);
        chk("R4 inhibit blocks other line", 1'b1);
        shclk_b = 1'b0;
        tick(4);
        chk("R3 falling edge holds", 1'b1);
        pulse(1'b0);
        chk("R2 shift after inhibit released", 1'b0);

        // R7: latency of a load
        par_in = 8'hFF;
        load_n = 1'b0;
        tick(2);
        chk("R7 not yet after two edges", 1'b0);
        tick(1);
        chk("R7 visible after third edge", 1'b1);
        load_n = 1'b1;
        tick(4);

        // R8: release with clock already high
        par_in = 8'h80;
        load_n = 1'b0;
        shclk_a = 1'b1;
        tick(4);
        load_n = 1'b1;
        tick(5);
        chk("R8 no shift with clock high at release", 1'b1);
        shclk_a = 1'b0;
        tick(3);
        // R8: clock rising together with release
        load_n = 1'b0;
        tick(4);
        load_n = 1'b1;
        shclk_a = 1'b1;
        tick(5);
        chk("R8 no shift when clock rises at release", 1'b1);
        shclk_a = 1'b0;
        tick(3);
        pulse(1'b1);
        chk("R2 shift via second line", 1'b0);

        // R9: reset in mid-run
        do_load(8'hFF);
        chk("R1 load FF", 1'b1);
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        chk("R9 reset clears stages", 1'b0);
        tick(4);
        chk("R6 outputs complementary after reset", 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule